// File: doc/BRIEF.md
# Synchronous Burst Read Wait-State Sequencer

This block sits between a simple request/response host port and an external flash-type memory that supports synchronous burst reads. For a burst read it drives the memory clock enable, chip select and a one-cycle address-valid strobe. It then counts a programmed initial latency of 1 to 16 memory clocks. After that it examines the memory's wait line on each memory clock to decide which cycles carry valid data. It returns exactly the requested number of valid beats and then releases chip select.

A per-access configuration controls several things: whether the wait line is honoured at all, the wait line's polarity, and whether the memory raises wait one data cycle ahead of the stall or during the stall itself. With burst mode off, reads fall back to single asynchronous accesses of a fixed length. Writes to a bank whose write permission is off are refused with a one-cycle bus error and cause no memory activity. The configuration is captured when a request is accepted, and changing it later has no effect on the access in flight. The memory clock is the block's own clock, gated by `mem_clk_en`.

Top module: `burst_wait_ctrl`

## Requirements
- R1: After reset, and at any time the block is idle, `req_ready`=1, `mem_cs_n`=1, `mem_we_n`=1, `mem_adv_n`=1, `mem_clk_en`=0, `rsp_valid`=0 and `rsp_err`=0.
- R2: A burst read accepted at edge e0 drives `mem_cs_n`=0, `mem_adv_n`=0, `mem_clk_en`=1 and `mem_addr`=request address for the one cycle after e0. `mem_adv_n` returns to 1 in the following cycle.
- R3: With latency field value C (0..15, meaning C+1 clocks), the first cycle in which wait is evaluated and data may be captured is C+3 cycles after the accept edge. A captured beat appears on `rsp_valid`/`rsp_data` in the next cycle.
- R4: With `cfg_wait_en`=0, the wait input is ignored and every memory cycle after the latency carries a valid beat.
- R5: The level of the wait input during the address and latency cycles has no effect.
- R6: `cfg_wait_pol`=0 treats `mem_wait`=0 as active. `cfg_wait_pol`=1 treats `mem_wait`=1 as active.
- R7: With `cfg_wait_late`=0 (early timing), active wait in burst cycle k makes cycle k+1 invalid. The first burst cycle is always valid.
- R8: With `cfg_wait_late`=1 (coincident timing), active wait in burst cycle k makes cycle k itself invalid.
- R9: A burst returns exactly `req_len` valid beats, with a length of 0 treated as 1. `mem_cs_n` rises in the same cycle that the last beat appears on `rsp_valid`.
- R10: With `cfg_burst_en`=0, a read is one asynchronous access. For ASYNC_CYC cycles it holds `mem_cs_n`=0, `mem_adv_n`=0 and `mem_clk_en`=0. `mem_rdata` is captured in the last of those cycles and returned with `rsp_valid` one cycle later, as `mem_cs_n` rises.
- R11: A write while `cfg_wr_en`=0 gives `rsp_err`=1 for exactly the one cycle after acceptance. `mem_cs_n` stays 1, and `rsp_err` never rises for any other request.
- R12: A write while `cfg_wr_en`=1 is an asynchronous access of ASYNC_CYC cycles with `mem_we_n`=0 and `mem_wdata`=request data. It completes with `rsp_valid`=1 and `rsp_data`=0.
- R13: Configuration inputs are captured at acceptance. Changing them during an access does not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_len | input | LW | Burst beats (0 treated as 1) |
| req_ready | output | 1 | Block idle, request accepted when valid |
| rsp_valid | output | 1 | One returned data beat / write done |
| rsp_data | output | DW | Returned data |
| rsp_err | output | 1 | Bus error for refused write |
| cfg_wait_en | input | 1 | Honour the wait input |
| cfg_wait_pol | input | 1 | 0 active-low wait, 1 active-high |
| cfg_wait_late | input | 1 | 0 early wait timing, 1 coincident |
| cfg_burst_en | input | 1 | 1 synchronous burst reads, 0 asynchronous |
| cfg_wr_en | input | 1 | Bank write permission |
| cfg_lat | input | 4 | Initial latency minus one |
| mem_clk_en | output | 1 | Memory clock running |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_wait | input | 1 | Wait line from memory |
| mem_rdata | input | DW | Read data from memory |

## Verification
Every result is due at a fixed number of cycles after the accept edge. The address phase is due 1 cycle after it. A burst cycle k carries its beat C+4+k cycles after it, when k is a valid cycle under the requirement rules. An asynchronous result is due ASYNC_CYC+1 cycles after it, and a refused write's error is due 1 cycle after it. The bench runs a cycle counter that restarts at each accept. It drives `mem_rdata` as an arithmetic function of that counter and the wait line as a function of the burst cycle index. On every falling edge it compares `rsp_valid`, and the data when a beat is due, against the value computed from the counter. A beat that arrives one cycle early or late therefore shows up as a miscompare on both cycles.

// File: rtl/bwc_pkg.sv
// Shared types for the burst wait-state sequencer.
// Assumes a 4-bit latency field (1..16 clocks).
package bwc_pkg;
    localparam int LAT_W = 4;

    typedef struct packed {
        logic             wait_en;
        logic             wait_pol;
        logic             wait_late;
        logic             burst_en;
        logic             wr_en;
        logic [LAT_W-1:0] lat;
    } bwc_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_LAT   = 3'd2,
        ST_BURST = 3'd3,
        ST_ASYNC = 3'd4
    } bwc_state_e;
endpackage

// File: rtl/bwc_down_cnt.sv
// Loadable down counter shared by the latency and asynchronous phases.
// Assumes load has priority over dec; dec at zero holds zero.
module bwc_down_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // Count register: load, decrement, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/bwc_wait_detect.sv
// Decides per burst cycle whether the memory data are valid.
// Assumes 'active' is high only in data cycles after the latency; the
// early-timing history is cleared whenever 'active' is low.
module bwc_wait_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic wait_en,
    input  logic wait_pol,
    input  logic wait_late,
    input  logic mem_wait,
    output logic beat_ok
);
    logic wait_act;
    logic wait_prev_q;

    // Normalise polarity: 1 means the memory requests a stall.
    assign wait_act = wait_en && (wait_pol ? mem_wait : !mem_wait);

    // Remember an early-timing wait for the following data cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wait_prev_q <= 1'b0;
        else
            wait_prev_q <= active && wait_act;
    end

    // Select which cycle the stall applies to.
    assign beat_ok = wait_late ? !wait_act : !wait_prev_q;
endmodule

// File: rtl/burst_wait_ctrl.sv
// Burst read sequencer with latency count and wait-state handling.
// Assumes the memory clock equals clk (gated by mem_clk_en) and that
// the host accepts every rsp_valid / rsp_err pulse without back-pressure.
module burst_wait_ctrl
    import bwc_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int LW        = 4,
    parameter int ASYNC_CYC = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [AW-1:0]        req_addr,
    input  logic [DW-1:0]        req_wdata,
    input  logic [LW-1:0]        req_len,
    output logic                 req_ready,
    output logic                 rsp_valid,
    output logic [DW-1:0]        rsp_data,
    output logic                 rsp_err,
    input  logic                 cfg_wait_en,
    input  logic                 cfg_wait_pol,
    input  logic                 cfg_wait_late,
    input  logic                 cfg_burst_en,
    input  logic                 cfg_wr_en,
    input  logic [LAT_W-1:0]     cfg_lat,
    output logic                 mem_clk_en,
    output logic                 mem_cs_n,
    output logic                 mem_adv_n,
    output logic                 mem_we_n,
    output logic [AW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata,
    input  logic                 mem_wait,
    input  logic [DW-1:0]        mem_rdata
);
    localparam int ACW   = $clog2(ASYNC_CYC + 1);
    localparam int CNT_W = (LAT_W > ACW) ? LAT_W : ACW;

    bwc_state_e       state_q;
    bwc_cfg_t         cfg_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    wdata_q;
    logic             wr_q;
    logic [LW-1:0]    beats_q;
    logic             rsp_valid_q;
    logic [DW-1:0]    rsp_data_q;
    logic             rsp_err_q;

    logic             accept;
    logic             refuse;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_dec;
    logic             cnt_zero;
    logic             in_burst;
    logic             beat_ok;

    assign accept   = req_valid && (state_q == ST_IDLE);
    assign refuse   = accept && req_write && !cfg_wr_en;
    assign in_burst = (state_q == ST_BURST);

    // Counter control: async length at accept, latency after address phase.
    always_comb begin
        cnt_load = 1'b0;
        cnt_val  = CNT_W'(ASYNC_CYC - 1);
        if (accept && !refuse && (req_write || !cfg_burst_en)) begin
            cnt_load = 1'b1;
        end else if (state_q == ST_ADDR) begin
            cnt_load = 1'b1;
            cnt_val  = CNT_W'(cfg_q.lat);
        end
    end
    assign cnt_dec = (state_q == ST_LAT) || (state_q == ST_ASYNC);

    bwc_down_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    bwc_wait_detect u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (in_burst),
        .wait_en   (cfg_q.wait_en),
        .wait_pol  (cfg_q.wait_pol),
        .wait_late (cfg_q.wait_late),
        .mem_wait  (mem_wait),
        .beat_ok   (beat_ok)
    );

    // Main sequencer: request capture, phase changes, beat capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cfg_q       <= '0;
            addr_q      <= '0;
            wdata_q     <= '0;
            wr_q        <= 1'b0;
            beats_q     <= '0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
            rsp_err_q   <= 1'b0;
        end else begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        cfg_q   <= '{wait_en: cfg_wait_en, wait_pol: cfg_wait_pol,
                                     wait_late: cfg_wait_late, burst_en: cfg_burst_en,
                                     wr_en: cfg_wr_en, lat: cfg_lat};
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        wr_q    <= req_write;
                        beats_q <= (req_len == '0) ? LW'(1) : req_len;
                        if (refuse)
                            rsp_err_q <= 1'b1;
                        else if (req_write || !cfg_burst_en)
                            state_q <= ST_ASYNC;
                        else
                            state_q <= ST_ADDR;
                    end
                end
                ST_ADDR: state_q <= ST_LAT;
                ST_LAT: begin
                    if (cnt_zero)
                        state_q <= ST_BURST;
                end
                ST_BURST: begin
                    if (beat_ok) begin
                        rsp_valid_q <= 1'b1;
                        rsp_data_q  <= mem_rdata;
                        beats_q     <= beats_q - 1'b1;
                        if (beats_q == LW'(1))
                            state_q <= ST_IDLE;
                    end
                end
                ST_ASYNC: begin
                    if (cnt_zero) begin
                        rsp_valid_q <= 1'b1;
                        rsp_data_q  <= wr_q ? '0 : mem_rdata;
                        state_q     <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign rsp_valid  = rsp_valid_q;
    assign rsp_data   = rsp_data_q;
    assign rsp_err    = rsp_err_q;
    assign mem_cs_n   = (state_q == ST_IDLE);
    assign mem_adv_n  = !((state_q == ST_ADDR) || (state_q == ST_ASYNC));
    assign mem_clk_en = (state_q == ST_ADDR) || (state_q == ST_LAT) || in_burst;
    assign mem_we_n   = !((state_q == ST_ASYNC) && wr_q);
    assign mem_addr   = addr_q;
    assign mem_wdata  = wdata_q;
endmodule

// File: rtl/bwc_checker.sv
// Protocol checker for burst_wait_ctrl, attached by bind below.
// Assumes it sees the captured configuration and the sequencer state.
module bwc_checker
    import bwc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_write,
    input logic       cfg_wr_en,
    input logic       rsp_valid,
    input logic       rsp_err,
    input logic       mem_cs_n,
    input logic       mem_we_n,
    input logic       mem_wait,
    input bwc_state_e st,
    input bwc_cfg_t   cfg
);
    logic burst;
    logic wact;
    assign burst = (st == ST_BURST);
    assign wact  = cfg.wait_pol ? mem_wait : !mem_wait;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_we_n));

    p_err_only_refused_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !(req_write && !cfg_wr_en)) |=> !rsp_err);

    p_err_no_select_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> mem_cs_n);

    p_wait_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (burst && !cfg.wait_en) |=> rsp_valid);

    p_coincident_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (burst && cfg.wait_en && cfg.wait_late && wact) |=> !rsp_valid);

    p_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (burst && cfg.wait_en && !cfg.wait_late && wact) |=> ##1 !rsp_valid);

    p_resp_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_err));
endmodule

bind burst_wait_ctrl bwc_checker u_bwc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .cfg_wr_en (cfg_wr_en),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_wait  (mem_wait),
    .st        (state_q),
    .cfg       (cfg_q)
);

// File: tb/test_burst_wait_ctrl.sv
// Sweep bench: every latency, wait mode and several wait patterns.
module test_burst_wait_ctrl;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int LW = 4;
    localparam int AC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [LW-1:0] req_len = '0;
    logic          req_ready, rsp_valid, rsp_err;
    logic [DW-1:0] rsp_data;
    logic          cfg_wait_en = 1'b1, cfg_wait_pol = 1'b0, cfg_wait_late = 1'b0;
    logic          cfg_burst_en = 1'b0, cfg_wr_en = 1'b1;
    logic [3:0]    cfg_lat = '0;
    logic          mem_clk_en, mem_cs_n, mem_adv_n, mem_we_n, mem_wait;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    int  vectors = 0;
    int  errors  = 0;
    int  tc      = 0;
    int  cur_l   = 1;
    int  cur_seed = 0;
    bit  cur_pol = 1'b0;

    burst_wait_ctrl #(.AW(AW), .DW(DW), .LW(LW), .ASYNC_CYC(AC)) i_burst_wait_ctrl (.*);

    function automatic logic [DW-1:0] data_at(int t);
        return DW'(t * 37 + 11);
    endfunction

    // Raw stall request at burst index k; always requested before burst.
    function automatic bit act_at(int k, int seed);
        if (k < 0) return 1'b1;
        return ((k + seed) % 3) == 0;
    endfunction

    always @(posedge clk) tc <= (req_valid && req_ready) ? 1 : tc + 1;

    assign mem_rdata = data_at(tc);
    assign mem_wait  = cur_pol ? act_at(tc - (cur_l + 2), cur_seed)
                               : !act_at(tc - (cur_l + 2), cur_seed);

    task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (tc=%0d)", rq, act, exp, tc);
        end
    endtask

    task automatic issue(bit wr, logic [LW-1:0] len);
        req_valid = 1'b1; req_write = wr; req_len = len;
        req_addr  = AW'(tc * 5 + 3);
        req_wdata = DW'(tc * 9 + 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        // R13: disturb every configuration input after acceptance
        cfg_wait_en = !cfg_wait_en; cfg_wait_pol = !cfg_wait_pol;
        cfg_wait_late = !cfg_wait_late; cfg_burst_en = !cfg_burst_en;
        cfg_wr_en = !cfg_wr_en; cfg_lat = ~cfg_lat;
    endtask

    task automatic burst(int c, bit we, bit pol, bit late, int seed, int len);
        int  l = c + 1;
        int  nexp = (len == 0) ? 1 : len;
        int  got = 0;
        logic [AW-1:0] a;
        @(negedge clk);
        cur_l = l; cur_seed = seed; cur_pol = pol;
        cfg_lat = 4'(c); cfg_wait_en = we; cfg_wait_pol = pol;
        cfg_wait_late = late; cfg_burst_en = 1'b1; cfg_wr_en = 1'b1;
        a = AW'(tc * 5 + 3);
        issue(1'b0, LW'(len));
        for (int cyc = 0; cyc < 200 && got < nexp; cyc++) begin
            int  k = tc - (l + 3);
            bit  ok_k = 1'b0;
            if (tc == 1) begin
                chk(!mem_cs_n && !mem_adv_n && mem_clk_en && mem_addr == a,
                    "R2 address phase", {mem_cs_n, mem_adv_n, mem_clk_en}, 3'b001);
            end
            if (tc == 2)
                chk(mem_adv_n == 1'b1, "R2 adv released", mem_adv_n, 1);
            if (k >= 0) begin
                if (!we) ok_k = 1'b1;                                  // R4
                else if (late) ok_k = !act_at(k, seed);                // R8
                else ok_k = (k == 0) ? 1'b1 : !act_at(k - 1, seed);    // R7, R5
            end
            chk(rsp_valid == ok_k, "R3/R6/R7/R8 beat timing", rsp_valid, ok_k);
            if (ok_k && rsp_valid) begin
                chk(rsp_data == data_at(tc - 1), "R3 beat data", rsp_data, data_at(tc - 1));
                got++;
                if (got == nexp)
                    chk(mem_cs_n == 1'b1, "R9 cs release at last beat", mem_cs_n, 1);
                else
                    chk(mem_cs_n == 1'b0, "R9 cs held mid burst", mem_cs_n, 0);
            end
            @(negedge clk);
        end
        chk(got == nexp, "R9 beat count", got, nexp);
        chk(!rsp_valid && req_ready, "R9 no extra beat", rsp_valid, 0);
    endtask

    task automatic async_acc(bit wr, bit wen);
        logic [DW-1:0] wd;
        @(negedge clk);
        cfg_burst_en = 1'b0; cfg_wr_en = wen; cfg_lat = 4'd9;
        wd = DW'(tc * 9 + 1);
        issue(wr, LW'(3));
        if (wr && !wen) begin
            chk(rsp_err && mem_cs_n && req_ready, "R11 refused write error", rsp_err, 1);
            @(negedge clk);
            chk(!rsp_err && mem_cs_n, "R11 error single cycle", rsp_err, 0);
            return;
        end
        for (int t = 1; t <= AC; t++) begin
            chk(!mem_cs_n && !mem_adv_n && !mem_clk_en && !rsp_valid && !rsp_err,
                wr ? "R12 write phase" : "R10 async phase",
                {mem_cs_n, mem_adv_n, mem_clk_en, rsp_valid}, 0);
            chk(mem_we_n == !wr, wr ? "R12 we asserted" : "R10 we idle", mem_we_n, !wr);
            if (wr) chk(mem_wdata == wd, "R12 write data", mem_wdata, wd);
            @(negedge clk);
        end
        chk(rsp_valid && mem_cs_n && mem_we_n, wr ? "R12 write done" : "R10 read done",
            rsp_valid, 1);
        chk(rsp_data == (wr ? '0 : data_at(AC)), wr ? "R12 zero data" : "R10 read data",
            rsp_data, wr ? 0 : data_at(AC));
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_cs_n && mem_we_n && mem_adv_n && !mem_clk_en && !rsp_valid
            && !rsp_err, "R1 reset state",
            {req_ready, mem_cs_n, mem_we_n, mem_adv_n, mem_clk_en, rsp_valid, rsp_err},
            7'b1111000);
        for (int c = 0; c < 16; c++)
            for (int m = 0; m < 8; m++)
                for (int s = 0; s < 3; s++)
                    burst(c, m[2], m[1], m[0], s, (s == 1) ? 1 : 5);
        burst(2, 1'b1, 1'b0, 1'b0, 0, 0);   // R9 length zero gives one beat
        burst(0, 1'b1, 1'b1, 1'b1, 2, 15);
        async_acc(1'b0, 1'b1);
        async_acc(1'b0, 1'b0);
        async_acc(1'b1, 1'b1);
        async_acc(1'b1, 1'b0);
        async_acc(1'b1, 1'b1);
        @(negedge clk);
        chk(req_ready && mem_cs_n && !rsp_err, "R1 idle after traffic", req_ready, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule